// File: doc/BRIEF.md
# Endpoint FIFO Segment Allocator

This block manages one pool of shared endpoint buffer memory. The memory is split into fixed 512-byte units, and a bitmap of 128 bits records which units are in use, so one pool spans up to 64 KB. A chip that moves data in both directions instantiates the block twice, once for the transmit pool and once for the receive pool. Each instance has its own base address and its own limit on how many units it may use.

An endpoint asks for space by presenting its maximum packet size and a count of extra packet slots. The block rounds the packet size up to a power of two to get the segment size. It multiplies that by the slot count plus one to get the region size. It then scans the bitmap from unit 0 upward for the first run of free units that is long enough. When the scan ends, the block reports either a byte address and size, or a failure. Space is handed back by presenting the region's address and size. The package defines the customary slot counts: two for a SuperSpeed-capable pool and one for a high-speed-only pool.

Top module: `ep_fifo_seg_alloc`

## Requirements
- R1: After reset every unit is free, done_valid is low, and req_ready and rel_ready are high.
- R2: The segment size is req_maxp rounded up to the next power of two, with 0 and 1 both giving 1. The region size reported on done_size is the segment size times (req_slots + 1), in bytes, for both success and failure.
- R3: A request occupies ceil(region bytes / 512) units, which is never fewer than one.
- R4: The chosen start unit is the lowest index s at which units s through s+n-1 are all free and s+n does not exceed the effective limit. The effective limit is pool_limit, or 128 when pool_limit is larger than 128.
- R5: On success done_addr equals pool_base plus the start unit times 512, and the start unit and every unit after it in the run are marked as in use.
- R6: When no run fits, done_fail is 1, done_addr is 0, and no unit changes state.
- R7: A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready stays low from acceptance until the result appears. done_valid is high for exactly one cycle, s+1 cycles after acceptance on success. On failure that delay is 1 cycle when the limit is below n, and otherwise (limit - n + 2) cycles.
- R8: A release accepted while idle frees the units from floor((rel_addr - pool_base)/512) up to and including that index plus ceil(rel_size/512) - 1, on the accepting edge. Freeing a unit that is already free has no effect. A release that is pending takes precedence: req_ready is low while rel_valid is high.
- R9: rel_ready is low while a scan is in progress, and no release changes the bitmap during a scan.
- R10: A release whose start offset from pool_base is 128 units or more, including one below pool_base, leaves the bitmap unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pool_base | input | ADDR_W | Byte address of unit 0 of the pool |
| pool_limit | input | LIM_W | Number of units the pool may use |
| req_valid | input | 1 | Allocation request present |
| req_ready | output | 1 | Allocation request can be accepted |
| req_maxp | input | MAXP_W | Endpoint maximum packet size in bytes |
| req_slots | input | SLOT_W | Extra packet slots beyond the first |
| rel_valid | input | 1 | Release request present |
| rel_ready | output | 1 | Release can be accepted |
| rel_addr | input | ADDR_W | Byte address of the region being freed |
| rel_size | input | SIZE_W | Byte size of the region being freed |
| done_valid | output | 1 | One-cycle result strobe |
| done_fail | output | 1 | No fitting run was found |
| done_addr | output | ADDR_W | Byte address of the granted region |
| done_size | output | SIZE_W | Region size in bytes |

## Verification
The assertions watch several properties on every cycle. Neither port accepts work while a scan runs. The result strobe lasts one cycle. A failed scan leaves the bitmap untouched. A successful scan raises the number of occupied units by exactly the unit count of the request. A granted address lies on the 512-byte grid. Marking and clearing never happen on the same edge. Which start unit first-fit picks, the exact scan latency, the rounding of odd packet sizes, and the effect of releases that free units twice, fall outside the pool, or arrive during a scan can only be shown by the bench scenarios. These scenarios run against a behavioural model of the bitmap.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_SCAN = 1'b1
   } scan_state_e;

   // customary extra-slot counts per pool flavour
   localparam int SLOTS_SUPERSPEED = 2;
   localparam int SLOTS_HIGHSPEED  = 1;
endpackage

// File: rtl/fsa_size_calc.sv
module fsa_size_calc #(
   parameter int MAXP_W  = 11,
   parameter int SLOT_W  = 2,
   parameter int UNIT_LG = 9,
   parameter int SIZE_W  = MAXP_W + SLOT_W + 1,
   parameter int UCW     = SIZE_W + 1
) (
   input  logic [MAXP_W-1:0] maxp,
   input  logic [SLOT_W-1:0] slots,
   output logic [SIZE_W-1:0] bytes,
   output logic [UCW-1:0]    units
);
   localparam int SEG_W = MAXP_W + 1;

   logic [MAXP_W-1:0] less_one;
   logic [SEG_W-1:0]  seg;
   logic [SIZE_W-1:0] mult;

   // power-of-two roundup: one above the top set bit of (maxp - 1)
   always_comb begin
      less_one = maxp - MAXP_W'(1);
      seg      = SEG_W'(1);
      if (maxp > MAXP_W'(1)) begin
         for (int i = 0; i < MAXP_W; i++) begin
            if (less_one[i]) seg = SEG_W'(1) << (i + 1);
         end
      end
   end

   assign mult  = SIZE_W'(slots) + SIZE_W'(1);
   assign bytes = SIZE_W'(seg) * mult;

   generate
      if (UNIT_LG == 0) begin : g_byte_units
         assign units = UCW'(bytes);
      end else begin : g_round_units
         logic [SIZE_W:0] padded;
         assign padded = {1'b0, bytes} + (SIZE_W + 1)'((1 << UNIT_LG) - 1);
         assign units  = UCW'(padded >> UNIT_LG);
      end
   endgenerate
endmodule

// File: rtl/fsa_range_mask.sv
module fsa_range_mask #(
   parameter int BITS = 128,
   parameter int SW   = 8,
   parameter int CW   = 15
) (
   input  logic [SW-1:0]   start,
   input  logic [CW-1:0]   count,
   output logic [BITS-1:0] mask
);
   logic [31:0] lo;
   logic [31:0] hi;

   assign lo = 32'(start);
   assign hi = 32'(start) + 32'(count);

   generate
      for (genvar b = 0; b < BITS; b++) begin : g_bit
         assign mask[b] = (32'(b) >= lo) && (32'(b) < hi);
      end
   endgenerate
endmodule

// File: rtl/fsa_occ_map.sv
module fsa_occ_map #(
   parameter int BITS = 128
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_en,
   input  logic [BITS-1:0] set_mask,
   input  logic            clr_en,
   input  logic [BITS-1:0] clr_mask,
   output logic [BITS-1:0] map
);
   generate
      for (genvar b = 0; b < BITS; b++) begin : g_unit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       map[b] <= 1'b0;
            else if (set_en && set_mask[b])   map[b] <= 1'b1;
            else if (clr_en && clr_mask[b])   map[b] <= 1'b0;
         end
      end
   endgenerate

   AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_en && clr_en)); // R9
endmodule

// File: rtl/ep_fifo_seg_alloc.sv
module ep_fifo_seg_alloc
   import fsa_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int MAP_BITS   = 128,
   parameter int UNIT_BYTES = 512,
   parameter int MAXP_W     = 11,
   parameter int SLOT_W     = 2,
   localparam int LIM_W     = $clog2(MAP_BITS + 1),
   localparam int SIZE_W    = MAXP_W + SLOT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pool_base,
   input  logic [LIM_W-1:0]  pool_limit,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [MAXP_W-1:0] req_maxp,
   input  logic [SLOT_W-1:0] req_slots,
   input  logic              rel_valid,
   output logic              rel_ready,
   input  logic [ADDR_W-1:0] rel_addr,
   input  logic [SIZE_W-1:0] rel_size,
   output logic              done_valid,
   output logic              done_fail,
   output logic [ADDR_W-1:0] done_addr,
   output logic [SIZE_W-1:0] done_size
);
   localparam int UNIT_LG = $clog2(UNIT_BYTES);
   localparam int IDX_W   = $clog2(MAP_BITS);
   localparam int CUR_W   = IDX_W + 1;
   localparam int UCW     = SIZE_W + 1;

   initial begin : elab_checks
      if ((UNIT_BYTES & (UNIT_BYTES - 1)) != 0)
         $error("UNIT_BYTES must be a power of two");
      if (MAP_BITS < 2)
         $error("MAP_BITS must be at least 2");
      if (ADDR_W < CUR_W + UNIT_LG)
         $error("ADDR_W too narrow for the pool span");
   end

   scan_state_e        state_q;
   logic [CUR_W-1:0]   cur_q;
   logic [UCW-1:0]     need_q;
   logic [SIZE_W-1:0]  bytes_q;
   logic [UCW-1:0]     req_units;
   logic [SIZE_W-1:0]  req_bytes;
   logic [MAP_BITS-1:0] map_q;
   logic [MAP_BITS-1:0] alloc_mask;
   logic [MAP_BITS-1:0] rel_mask;
   logic               idle, scanning, req_fire, rel_fire;
   logic [31:0]        eff_limit, run_end;
   logic               over, clash, fit, miss;
   logic [ADDR_W-1:0]  rel_off, rel_idx;
   logic               in_pool;
   logic [UCW-1:0]     rel_units;
   logic [UCW:0]       rel_pad;

   assign idle      = (state_q == ST_IDLE);
   assign scanning  = (state_q == ST_SCAN);
   assign rel_ready = idle;
   assign req_ready = idle && !rel_valid;
   assign req_fire  = req_valid && req_ready;
   assign rel_fire  = rel_valid && idle;

   // ---------------- request sizing ----------------
   fsa_size_calc #(
      .MAXP_W (MAXP_W),
      .SLOT_W (SLOT_W),
      .UNIT_LG(UNIT_LG),
      .SIZE_W (SIZE_W),
      .UCW    (UCW)
   ) u_size (
      .maxp (req_maxp),
      .slots(req_slots),
      .bytes(req_bytes),
      .units(req_units)
   );

   // ---------------- candidate window ----------------
   fsa_range_mask #(
      .BITS(MAP_BITS),
      .SW  (CUR_W),
      .CW  (UCW)
   ) u_cand (
      .start(cur_q),
      .count(need_q),
      .mask (alloc_mask)
   );

   assign eff_limit = (32'(pool_limit) > 32'(MAP_BITS)) ? 32'(MAP_BITS) : 32'(pool_limit);
   assign run_end   = 32'(cur_q) + 32'(need_q);
   assign over      = run_end > eff_limit;
   assign clash     = |(map_q & alloc_mask);
   assign fit       = scanning && !over && !clash;
   assign miss      = scanning && over;

   // ---------------- release decode ----------------
   assign rel_off   = rel_addr - pool_base;
   assign rel_idx   = rel_off >> UNIT_LG;
   assign in_pool   = rel_idx < ADDR_W'(MAP_BITS);
   assign rel_pad   = (UCW + 1)'(rel_size) + (UCW + 1)'(UNIT_BYTES - 1);
   assign rel_units = UCW'(rel_pad >> UNIT_LG);

   fsa_range_mask #(
      .BITS(MAP_BITS),
      .SW  (CUR_W),
      .CW  (UCW)
   ) u_rel (
      .start(rel_idx[CUR_W-1:0]),
      .count(rel_units),
      .mask (rel_mask)
   );

   // ---------------- occupancy bitmap ----------------
   fsa_occ_map #(
      .BITS(MAP_BITS)
   ) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (fit),
      .set_mask(alloc_mask),
      .clr_en  (rel_fire && in_pool),
      .clr_mask(rel_mask),
      .map     (map_q)
   );

   // ---------------- scan control ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cur_q      <= '0;
         need_q     <= '0;
         bytes_q    <= '0;
         done_valid <= 1'b0;
         done_fail  <= 1'b0;
         done_addr  <= '0;
         done_size  <= '0;
      end else begin
         done_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_fire) begin
                  need_q  <= req_units;
                  bytes_q <= req_bytes;
                  cur_q   <= '0;
                  state_q <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (miss) begin
                  done_valid <= 1'b1;
                  done_fail  <= 1'b1;
                  done_addr  <= '0;
                  done_size  <= bytes_q;
                  state_q    <= ST_IDLE;
               end else if (fit) begin
                  done_valid <= 1'b1;
                  done_fail  <= 1'b0;
                  done_addr  <= pool_base + (ADDR_W'(cur_q) << UNIT_LG);
                  done_size  <= bytes_q;
                  state_q    <= ST_IDLE;
               end else begin
                  cur_q <= cur_q + CUR_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- checks ----------------
   AST_SCAN_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R7
   AST_SCAN_BLOCKS_REL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !rel_ready); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid); // R7
   AST_UNITS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (need_q != '0)); // R3
   AST_FAIL_KEEPS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_fail) |-> (map_q == $past(map_q))); // R6
   AST_FIT_MARKS_UNITS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_fail) |->
         ($countones(map_q) == $countones($past(map_q)) + int'(need_q))); // R4
   AST_ADDR_ON_GRID: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_fail) |->
         (((done_addr - pool_base) & ADDR_W'(UNIT_BYTES - 1)) == '0)); // R5
endmodule

// File: tb/ep_fifo_seg_alloc_test.sv
`timescale 1ns/1ps
module ep_fifo_seg_alloc_test;
   localparam logic [31:0] BASE = 32'h0004_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pool_base = BASE;
   logic [7:0]  pool_limit = 8'd128;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [10:0] req_maxp = '0;
   logic [1:0]  req_slots = '0;
   logic        rel_valid = 1'b0;
   logic        rel_ready;
   logic [31:0] rel_addr = '0;
   logic [13:0] rel_size = '0;
   logic        done_valid, done_fail;
   logic [31:0] done_addr;
   logic [13:0] done_size;

   int checks = 0;
   int failures = 0;
   bit run_cmp = 1'b0;

   always #4 clk = ~clk;

   ep_fifo_seg_alloc uut (
      .clk(clk), .rst_n(rst_n), .pool_base(pool_base), .pool_limit(pool_limit),
      .req_valid(req_valid), .req_ready(req_ready), .req_maxp(req_maxp),
      .req_slots(req_slots), .rel_valid(rel_valid), .rel_ready(rel_ready),
      .rel_addr(rel_addr), .rel_size(rel_size), .done_valid(done_valid),
      .done_fail(done_fail), .done_addr(done_addr), .done_size(done_size)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   logic [127:0] m_map = '0;
   bit     m_busy = 1'b0;
   int     m_cnt = 0;
   bit     p_fail = 1'b0;
   int     p_start = 0, p_need = 0, p_bytes = 0;
   bit     e_done = 1'b0, e_fail = 1'b0;
   longint e_addr = 0, e_size = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_map = '0; m_busy = 0; m_cnt = 0; e_done = 0; e_fail = 0; e_addr = 0; e_size = 0;
      end else begin
         e_done = 0;
         if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_busy = 0;
               e_done = 1;
               e_fail = p_fail;
               e_size = p_bytes;
               e_addr = p_fail ? 0 : longint'(pool_base) + p_start * 512;
               if (!p_fail) for (int u = p_start; u < p_start + p_need; u++) m_map[u] = 1'b1;
            end
         end else if (rel_valid) begin
            logic [31:0] off;
            int idx, n;
            off = rel_addr - pool_base;
            if (off / 512 < 128) begin
               idx = int'(off / 512);
               n = (int'(rel_size) + 511) / 512;
               for (int u = idx; u < idx + n && u < 128; u++) m_map[u] = 1'b0;
            end
         end else if (req_valid) begin
            int seg, lim;
            bit ok;
            seg = 1;
            while (seg < int'(req_maxp)) seg = seg * 2;
            p_bytes = seg * (int'(req_slots) + 1);
            p_need = (p_bytes + 511) / 512;
            lim = (pool_limit > 128) ? 128 : int'(pool_limit);
            p_fail = 1;
            for (int s = 0; s + p_need <= lim && p_fail; s++) begin
               ok = 1;
               for (int u = s; u < s + p_need; u++) if (m_map[u]) ok = 0;
               if (ok) begin p_fail = 0; p_start = s; end
            end
            if (p_fail) m_cnt = ((lim >= p_need) ? (lim - p_need + 1) : 0) + 1;
            else        m_cnt = p_start + 1;
            m_busy = 1;
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      #2;
      if (rst_n && run_cmp) begin
         chk("R7", "done_valid", done_valid, e_done);
         if (e_done && done_valid) begin
            chk("R6", "done_fail", done_fail, e_fail);
            chk("R4/R5", "done_addr", done_addr, e_addr);
            chk("R2/R3", "done_size", done_size, e_size);
         end
         chk("R7/R8", "req_ready", req_ready, (!m_busy && !rel_valid));
         chk("R9", "rel_ready", rel_ready, !m_busy);
      end
   end

   // ---------------- directed helpers ----------------
   task automatic alloc(input int maxp, input int slots, input bit xfail,
                        input int xunit, input int xsize, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_maxp = 11'(maxp); req_slots = 2'(slots);
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      req_valid = 1'b0;
      #2;
      while (!done_valid) begin @(negedge clk); #2; end
      chk(tag, "fail flag", done_fail, xfail);
      if (!xfail) chk(tag, "address", done_addr, longint'(BASE) + xunit * 512);
      chk(tag, "size", done_size, xsize);
   endtask

   task automatic release_region(input longint addr, input int size);
      @(negedge clk);
      rel_valid = 1'b1; rel_addr = 32'(addr); rel_size = 14'(size);
      #1;
      while (!rel_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      rel_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin : watchdog
      repeat (60000) @(posedge clk);
      failures++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 60000, 0);
      finish_run();
   end

   initial begin : stimulus
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk("R1", "done_valid after reset", done_valid, 0);
      chk("R1", "req_ready after reset", req_ready, 1);
      chk("R1", "rel_ready after reset", rel_ready, 1);
      run_cmp = 1'b1;

      // R1 R4: empty map, first region at unit 0; R2 R3: 1024 -> 6 units
      alloc(1024, fsa_pkg::SLOTS_SUPERSPEED, 0, 0, 3072, "R1/R4");
      alloc(100, fsa_pkg::SLOTS_HIGHSPEED, 0, 6, 256, "R3");   // 128*2 -> one unit
      alloc(513, 0, 0, 7, 1024, "R2");                         // rounds to 1024
      release_region(BASE, 3072);                              // R8 free 0..5
      alloc(512, 3, 0, 0, 2048, "R8");                         // reuses hole
      alloc(1024, 1, 0, 9, 2048, "R4");                        // skips short gap
      release_region(BASE + 128 * 512, 512);                   // R10 ignored
      alloc(64, 0, 0, 4, 64, "R10");
      release_region(BASE + 3072, 512);                        // R8 free twice
      release_region(BASE + 3072, 512);
      alloc(64, 0, 0, 5, 64, "R8");
      alloc(64, 0, 0, 6, 64, "R8");

      // limit handling
      pool_limit = 8'd16;
      alloc(1024, 1, 1, 0, 2048, "R6");                        // 13+4 > 16
      alloc(1024, 0, 0, 13, 1024, "R6");                       // map unchanged
      alloc(1024, 0, 1, 0, 1024, "R4");                        // 15+2 > 16
      alloc(8, 0, 0, 15, 8, "R4");                             // ends at limit

      // clamp above 128, fill the pool
      pool_limit = 8'd200;
      release_region(BASE, 8192);
      release_region(BASE + 8192, 8192);
      for (int k = 0; k < 16; k++) alloc(1024, 3, 0, 8 * k, 4096, "R4");
      alloc(1024, 3, 1, 0, 4096, "R6");

      // R9: release held during a scan waits for it
      @(negedge clk);
      req_valid = 1'b1; req_maxp = 11'd64; req_slots = 2'd0;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      req_valid = 1'b0;
      rel_valid = 1'b1; rel_addr = BASE + 40 * 512; rel_size = 14'd512;
      #1;
      chk("R9", "rel_ready during scan", rel_ready, 0);
      #1;
      while (!done_valid) begin @(negedge clk); #2; end
      chk("R9", "scan result with pending release", done_fail, 1);
      @(negedge clk);
      rel_valid = 1'b0;
      alloc(0, 0, 0, 40, 1, "R2");                             // 0 treated as 1

      // R8: release beats a simultaneous request
      @(negedge clk);
      rel_valid = 1'b1; rel_addr = BASE + 41 * 512; rel_size = 14'd1;
      req_valid = 1'b1; req_maxp = 11'd0; req_slots = 2'd0;
      #1;
      chk("R8", "req_ready with release pending", req_ready, 0);
      @(negedge clk);
      rel_valid = 1'b0;
      #1;
      chk("R8", "req_ready after release", req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0;
      #2;
      while (!done_valid) begin @(negedge clk); #2; end
      chk("R8", "address after precedence", done_addr, longint'(BASE) + 41 * 512);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule